// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block computes integer quotients and remainders over several clock cycles, one quotient bit per cycle, using a shift-and-subtract datapath. It handles signed and unsigned operands, plain and extended division (the dividend is the first operand followed by a full operand width of zero bits), and remainder operations. A word mode runs the same datapath on the low half of each operand. Decode and register-file access happen outside the block.

A caller presents an opcode, the word-mode bit and two operands, and pulses `start` while `busy` is low. When the result is ready, `done` is high for one cycle together with `result`, an overflow flag and a write enable for the flag registers. The divider detects division by zero, the signed most-negative by minus-one case, and quotients that do not fit the result width. In each of these cases it raises the overflow flag and forces the result to zero. Remainder operations never request a flag write.

Top module: `div_unit`

## Requirements
- R1: Opcode 0 is unsigned divide; the quotient is `a / b` truncated. If the divisor is zero, ovf is 1.
- R2: Opcode 1 is signed divide; the quotient truncates toward zero. If the divisor is zero, or if the dividend is the most negative value and the divisor is all ones, ovf is 1.
- R3: Opcode 4 is the unsigned remainder and opcode 5 is the signed remainder; a signed remainder takes the sign of the dividend. Their overflow conditions match opcodes 0 and 1 respectively.
- R4: Opcode 2 is unsigned extended divide: (a shifted left by the width) / b. It is valid only when a < b; otherwise ovf is 1.
- R5: Opcode 3 is signed extended divide: (a shifted left by the width) / b, both signed. If b is zero, or if the quotient falls outside the signed range of the width, ovf is 1.
- R6: With `word` = 1, only the low XLEN/2 bits of each operand are used, so changing the upper bits has no effect. The XLEN/2-bit result is zero-extended to XLEN bits.
- R7: Whenever ovf is 1 at done, result is zero.
- R8: At done, flag_we is 1 for opcodes 0 to 3 and 0 for opcodes 4 and 5. Outside done, ovf and flag_we are 0.
- R9: An accepted start raises busy in the next cycle. done is a one-cycle pulse that rises XLEN+1 clock edges after the edge that sampled start, and busy is low while done is high.
- R10: A start while busy is ignored. result holds its value until the next done.
- R11: After reset, busy, done, result, ovf and flag_we are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| op | input | 3 | Operation code (0..5, see requirements) |
| word | input | 1 | Operate on the low half of the operands |
| opa | input | XLEN | Dividend operand |
| opb | input | XLEN | Divisor operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| result | output | XLEN | Quotient or remainder |
| ovf | output | 1 | Overflow / invalid result at done |
| flag_we | output | 1 | Flag registers may be written at done |

## Verification
The hardest case to reach is the signed extended quotient that lands exactly on the edge of the signed range. Here the magnitude test passes, but the quotient is either the most negative value, which is legal, or its positive mirror, which overflows. The bench builds the unit with an 8-bit width. It sweeps every pair of 4-bit operands in word mode and a dense lattice of 8-bit pairs in full mode, with extremal values added. This covers every sign combination and every boundary quotient, and the expected value comes from plain integer arithmetic. A separate sequence fires start mid-operation and checks that the first result survives.

// File: rtl/divu_pkg.sv
package divu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

    // op bit0 = signed, bit1 = extended (divide only), bit2 = remainder
    typedef struct packed {
        logic sgn;
        logic ext;
        logic modo;
        logic word;
    } div_ctl_t;

    function automatic div_ctl_t decode_op(logic [2:0] op, logic word);
        div_ctl_t c;
        c.sgn  = op[0];
        c.modo = op[2];
        c.ext  = op[1] & ~op[2];
        c.word = word;
        return c;
    endfunction

endpackage

// File: rtl/div_prep.sv
module div_prep #(
    parameter int XLEN = 64
) (
    input  logic            sgn,
    input  logic            ext,
    input  logic            word,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] rem_init,
    output logic [XLEN-1:0] quo_init,
    output logic [XLEN-1:0] dvs,
    output logic            neg_q,
    output logic            neg_r,
    output logic            pre_ovf
);
    localparam int H = XLEN / 2;

    logic            a_neg, b_neg, a_min, b_ones;
    logic [XLEN-1:0] a_x, b_x, mag_a, mag_b;

    always_comb begin
        a_neg  = sgn & (word ? opa[H-1] : opa[XLEN-1]);
        b_neg  = sgn & (word ? opb[H-1] : opb[XLEN-1]);
        a_x    = word ? {{H{a_neg}}, opa[H-1:0]} : opa;
        b_x    = word ? {{H{b_neg}}, opb[H-1:0]} : opb;
        mag_a  = a_neg ? -a_x : a_x;
        mag_b  = b_neg ? -b_x : b_x;
        a_min  = word ? (opa[H-1:0] == {1'b1, {(H-1){1'b0}}})
                      : (opa == {1'b1, {(XLEN-1){1'b0}}});
        b_ones = word ? (&opb[H-1:0]) : (&opb);
        pre_ovf = (mag_b == '0)
                | (sgn & ~ext & a_min & b_ones)
                | (ext & ~(mag_a < mag_b));
        neg_q  = a_neg ^ b_neg;
        neg_r  = a_neg;
        dvs    = mag_b;
        if (ext && !word) begin
            rem_init = mag_a;
            quo_init = '0;
        end else if (ext) begin
            rem_init = '0;
            quo_init = mag_a << H;
        end else begin
            rem_init = '0;
            quo_init = mag_a;
        end
    end
endmodule

// File: rtl/div_core.sv
module div_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic [XLEN-1:0] rem_init,
    input  logic [XLEN-1:0] quo_init,
    input  logic [XLEN-1:0] dvs,
    output logic [XLEN-1:0] rem,
    output logic [XLEN-1:0] quo
);
    logic [XLEN-1:0] d_q;
    logic [XLEN:0]   trial, diff;
    logic            take;

    always_comb begin
        trial = {rem, quo[XLEN-1]};
        diff  = trial - {1'b0, d_q};
        take  = trial >= {1'b0, d_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
            quo <= '0;
            d_q <= '0;
        end else if (load) begin
            rem <= rem_init;
            quo <= quo_init;
            d_q <= dvs;
        end else if (step) begin
            rem <= take ? diff[XLEN-1:0] : trial[XLEN-1:0];
            quo <= {quo[XLEN-2:0], take};
        end
    end
endmodule

// File: rtl/div_post.sv
module div_post #(
    parameter int XLEN = 64
) (
    input  logic            sgn,
    input  logic            ext,
    input  logic            modo,
    input  logic            word,
    input  logic            neg_q,
    input  logic            neg_r,
    input  logic            pre_ovf,
    input  logic [XLEN-1:0] quo,
    input  logic [XLEN-1:0] rem,
    output logic [XLEN-1:0] res,
    output logic            ovf
);
    localparam int H = XLEN / 2;

    logic [XLEN-1:0] q_s, r_s, val, lim;
    logic            fit;

    always_comb begin
        q_s = neg_q ? -quo : quo;
        r_s = neg_r ? -rem : rem;
        lim = word ? (XLEN'(1) << (H - 1)) : (XLEN'(1) << (XLEN - 1));
        fit = neg_q ? (quo <= lim) : (quo < lim);
        ovf = pre_ovf | (sgn & ext & ~fit);
        val = modo ? r_s : q_s;
        if (word) val = {{H{1'b0}}, val[H-1:0]};
        res = ovf ? '0 : val;
    end
endmodule

// File: rtl/div_unit.sv
module div_unit
    import divu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [2:0]      op,
    input  logic            word,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic            ovf,
    output logic            flag_we
);
    localparam int CW = $clog2(XLEN + 1);

    div_state_e      state;
    logic [CW-1:0]   cnt;
    div_ctl_t        ctl_in, ctl_q;
    logic            nq_in, nr_in, po_in, nq_q, nr_q, po_q;
    logic [XLEN-1:0] rem_init, quo_init, dvs, rem, quo, res_c;
    logic            ovf_c, accept;

    assign ctl_in = decode_op(op, word);
    assign accept = start && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

    div_prep #(.XLEN(XLEN)) u_prep (
        .sgn(ctl_in.sgn), .ext(ctl_in.ext), .word(ctl_in.word),
        .opa(opa), .opb(opb),
        .rem_init(rem_init), .quo_init(quo_init), .dvs(dvs),
        .neg_q(nq_in), .neg_r(nr_in), .pre_ovf(po_in)
    );

    div_core #(.XLEN(XLEN)) u_core (
        .clk(clk), .rst(rst), .load(accept), .step(state == ST_RUN),
        .rem_init(rem_init), .quo_init(quo_init), .dvs(dvs),
        .rem(rem), .quo(quo)
    );

    div_post #(.XLEN(XLEN)) u_post (
        .sgn(ctl_q.sgn), .ext(ctl_q.ext), .modo(ctl_q.modo), .word(ctl_q.word),
        .neg_q(nq_q), .neg_r(nr_q), .pre_ovf(po_q),
        .quo(quo), .rem(rem), .res(res_c), .ovf(ovf_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            ctl_q   <= '0;
            nq_q    <= 1'b0;
            nr_q    <= 1'b0;
            po_q    <= 1'b0;
            done    <= 1'b0;
            result  <= '0;
            ovf     <= 1'b0;
            flag_we <= 1'b0;
        end else begin
            done    <= 1'b0;
            ovf     <= 1'b0;
            flag_we <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    ctl_q <= ctl_in;
                    nq_q  <= nq_in;
                    nr_q  <= nr_in;
                    po_q  <= po_in;
                    cnt   <= CW'(XLEN);
                    state <= ST_RUN;
                end
                ST_RUN: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == CW'(1)) state <= ST_FIN;
                end
                ST_FIN: begin
                    result  <= res_c;
                    ovf     <= ovf_c;
                    flag_we <= ~ctl_q.modo;
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/div_unit_chk.sv
module div_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result,
    input logic            ovf,
    input logic            flag_we
);
    p_ovf_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (done && ovf) |-> (result == '0));

    p_flags_gated_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> (!ovf && !flag_we));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_start_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));
endmodule

bind div_unit div_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .result(result), .ovf(ovf), .flag_we(flag_we)
);

// File: tb/div_unit_test.sv
module div_unit_test;
    localparam int XL = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [2:0]    op_i = '0;
    logic          word_i = 1'b0;
    logic [XL-1:0] a_i = '0, b_i = '0;
    logic          busy, done, ovf, flag_we;
    logic [XL-1:0] result;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    div_unit #(.XLEN(XL)) uut (
        .clk(clk), .rst(rst), .start(start_i), .op(op_i), .word(word_i),
        .opa(a_i), .opb(b_i), .busy(busy), .done(done), .result(result),
        .ovf(ovf), .flag_we(flag_we)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Arithmetic reference derived from the requirements
    task automatic model(input int op, input bit wd, input int a, input int b,
                         output int r, output bit o);
        int w, mask, ua, ub, sa, sb, q;
        w = wd ? XL / 2 : XL;
        mask = (1 << w) - 1;
        ua = a & mask;
        ub = b & mask;
        sa = (ua >= (1 << (w - 1))) ? ua - (1 << w) : ua;
        sb = (ub >= (1 << (w - 1))) ? ub - (1 << w) : ub;
        o = 1'b0;
        q = 0;
        case (op)
            0: if (ub == 0) o = 1'b1; else q = ua / ub;
            1: if (ub == 0 || (ua == (1 << (w - 1)) && ub == mask)) o = 1'b1; else q = sa / sb;
            2: if (ua >= ub) o = 1'b1; else q = (ua << w) / ub;
            3: if (ub == 0) o = 1'b1;
               else begin
                   q = (sa * (1 << w)) / sb;
                   if (q < -(1 << (w - 1)) || q > (1 << (w - 1)) - 1) o = 1'b1;
               end
            4: if (ub == 0) o = 1'b1; else q = ua % ub;
            default: if (ub == 0 || (ua == (1 << (w - 1)) && ub == mask)) o = 1'b1; else q = sa % sb;
        endcase
        r = o ? 0 : (q & mask);
    endtask

    function automatic string op_tag(input int op, input bit wd);
        if (wd) return "R6";
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R4";
            3: return "R5";
            default: return "R3";
        endcase
    endfunction

    task automatic run_op(input int op, input bit wd, input int a, input int b);
        int lat, er;
        bit eo;
        @(negedge clk);
        op_i = 3'(op); word_i = wd; a_i = XL'(a); b_i = XL'(b); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        model(op, wd, a, b, er, eo);
        chk("R9 latency", lat, XL + 2);
        chk(op_tag(op, wd), int'(result), er);
        chk(op_tag(op, wd), int'(ovf), int'(eo));
        if (eo) chk("R7", int'(result), 0);
        chk("R8", int'(flag_we), (op < 4) ? 1 : 0);
        chk("R9 busy", int'(busy), 0);
        @(negedge clk);
        chk("R9 pulse", int'(done), 0);
        chk("R8 gated", int'(ovf | flag_we), 0);
    endtask

    initial begin
        #(10ns * 190000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int sp[5];
        sp = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11", int'({busy, done, ovf, flag_we}), 0);
        chk("R11", int'(result), 0);

        // Word mode: exhaustive low halves, junk in upper halves (R6)
        for (int op = 0; op < 6; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run_op(op, 1'b1, ((a * 5 + b) & 15) << 4 | a, ((b * 3 + 7) & 15) << 4 | b);

        // Full width lattice
        for (int op = 0; op < 6; op++)
            for (int a = 0; a < 256; a += 13)
                for (int b = 0; b < 256; b += 7)
                    run_op(op, 1'b0, a, b);

        // Extremal operands (R2, R3, R5 boundaries)
        for (int op = 0; op < 6; op++)
            foreach (sp[i])
                foreach (sp[j])
                    run_op(op, 1'b0, sp[i], sp[j]);

        // Signed extended edge: -64/... quotient exactly min vs +max+1 (R5)
        run_op(3, 1'b0, 8'hC0, 8'h80);
        run_op(3, 1'b0, 8'h40, 8'h80);
        run_op(3, 1'b0, 8'h40, 8'h7F);

        // R10: start while busy is ignored, result held afterwards
        begin
            int lat, er, held;
            bit eo;
            @(negedge clk);
            op_i = 3'd0; word_i = 1'b0; a_i = 8'd200; b_i = 8'd7; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (2) @(negedge clk);
            op_i = 3'd4; a_i = 8'd9; b_i = 8'd4; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            lat = 4;
            while (!done && lat < 40) begin
                @(negedge clk);
                lat++;
            end
            model(0, 1'b0, 200, 7, er, eo);
            chk("R10 latency", lat, XL + 2);
            chk("R10 first result", int'(result), er);
            held = int'(result);
            lat = 0;
            repeat (14) begin
                @(negedge clk);
                if (done) lat++;
            end
            chk("R10 no second done", lat, 0);
            chk("R10 hold", int'(result), held);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule